// File: doc/BRIEF.md
# Register-Mapped Signed Divider

This block is a small bank of 32-bit registers with a signed divider behind it. Software loads a divisor, then writes a dividend word; the write itself launches the division. There are two launch points. One treats the written word as a 32-bit signed dividend. The other treats it as the low half of a 64-bit signed dividend, whose high half is the word already held in the high-dividend register.

The quotient rounds toward zero and the remainder carries the sign of the dividend. Results land in fixed registers, and each is also copied to a mirror register. A quotient that cannot be held in 32 signed bits saturates. A zero divisor clears the result registers.

The datapath is iterative and non-restoring on magnitudes, one quotient bit per cycle, and runs 64 steps for both forms. A `busy` output is high for the whole operation. While it is high the register bank is frozen and ignores writes. All offsets below are byte offsets; the low two address bits are ignored.

Top module: `sdiv_mmio`

## Requirements
- R1: After reset, `busy` is low and every register (0x100, 0x104, 0x110, 0x114, 0x118, 0x11C) reads zero.
- R2: While idle, a write to any of the six register offsets stores the data, and a read of that offset returns it. Only a write to 0x104 or 0x114 starts a division.
- R3: A write to 0x104 while idle starts a division of the written word, taken as a signed 32-bit value, by the signed word at 0x100.
- R4: When a division started at 0x104 completes, the quotient is held at 0x104, 0x114 and 0x11C, and the remainder at 0x110 and 0x118.
- R5: A write to 0x114 while idle divides the signed 64-bit value {word at 0x110, written word} by the divisor. On completion the remainder is at 0x110 and 0x118 and the quotient at 0x114 and 0x11C; 0x104 is unchanged.
- R6: The quotient is truncated toward zero, and the remainder has the sign of the dividend (dividend = quotient × divisor + remainder).
- R7: A quotient above 2^31−1 reads 0x7FFFFFFF, and one below −2^31 reads 0x80000000. This includes 0x80000000 divided by −1 in the 32-bit form. A quotient of exactly −2^31 is not saturated, and the remainder is always the true remainder.
- R8: With a zero divisor, 0x110, 0x114, 0x118 and 0x11C all read zero after completion. In the 32-bit form, 0x104 keeps the written dividend.
- R9: `busy` rises at the clock edge that accepts the starting write and stays high for exactly 65 cycles. The results are readable in the first cycle after it falls.
- R10: While `busy` is high, every write is ignored, including writes to the start offsets. Reads of 0x110 during that time return the value held before the start.
- R11: Reads of any offset outside the six registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | 9 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data for `rd_addr` |
| busy | output | 1 | High while a division is in progress |

## Verification
The assertions assume a write strobe lasts one cycle and that `wr_addr` is meaningful whenever `wr_en` is high. They also assume that nothing other than the bus writes can change the bank, so a frozen divisor and equal mirrors can be checked at the edge where `busy` falls. The stimulus drives every write for exactly one cycle, changes inputs only on the falling clock edge, and issues reads through the read port alone. It waits for `busy` to fall before each new launch, except in the one sequence that deliberately writes during `busy` to show that those writes are dropped.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    // byte offsets of the register bank (software-visible, behaviour depends on them)
    localparam int OFS_DVSR  = 'h100;
    localparam int OFS_DVD32 = 'h104;
    localparam int OFS_HI    = 'h110;
    localparam int OFS_LO    = 'h114;
    localparam int OFS_REMM  = 'h118;
    localparam int OFS_QUOM  = 'h11C;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;
endpackage

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
    parameter int DW = 32
) (
    input  logic [DW+1:0]   p_in,
    input  logic [2*DW-1:0] qmag_in,
    input  logic [DW-1:0]   dmag_in,
    input  logic            neg_q_in,
    input  logic            neg_r_in,
    output logic            dz_o,
    output logic [DW-1:0]   quo_o,
    output logic [DW-1:0]   rem_o
);
    localparam int QW = 2 * DW;
    localparam int PW = DW + 2;
    localparam logic [DW-1:0] Q_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] Q_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [PW-1:0] rfix;
    logic [QW-1:0] lim;
    logic          ovf;

    always_comb begin
        // single remainder correction of the non-restoring sequence
        rfix = p_in[PW-1] ? (p_in + {2'b00, dmag_in}) : p_in;
        lim  = (QW'(1) << (DW - 1)) - (neg_q_in ? QW'(0) : QW'(1));
        ovf  = (qmag_in > lim);
        dz_o = (dmag_in == '0);

        if (dz_o) begin
            quo_o = '0;
        end else if (ovf) begin
            quo_o = neg_q_in ? Q_MIN : Q_MAX;
        end else begin
            quo_o = neg_q_in ? (-qmag_in[DW-1:0]) : qmag_in[DW-1:0];
        end

        if (dz_o) begin
            rem_o = '0;
        end else begin
            rem_o = neg_r_in ? (-rfix[DW-1:0]) : rfix[DW-1:0];
        end
    end
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2*DW-1:0] dvd,
    input  logic [DW-1:0]   dvs,
    output logic            busy,
    output logic            done,
    output logic            dz,
    output logic [DW-1:0]   quo,
    output logic [DW-1:0]   rem
);
    import sdiv_pkg::*;

    localparam int QW = 2 * DW;
    localparam int PW = DW + 2;
    localparam int CW = $clog2(QW);

    typedef struct packed {
        div_state_e    state;
        logic [CW-1:0] cnt;
        logic [PW-1:0] p;
        logic [QW-1:0] q;
        logic [DW-1:0] d;
        logic          neg_q;
        logic          neg_r;
    } core_s;

    core_s c_q, c_d;
    logic [PW-1:0] pin, pnext;

    always_comb begin
        c_d   = c_q;
        pin   = {c_q.p[PW-2:0], c_q.q[QW-1]};
        pnext = c_q.p[PW-1] ? (pin + {2'b00, c_q.d}) : (pin - {2'b00, c_q.d});
        case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.state = ST_STEP;
                    c_d.cnt   = '0;
                    c_d.p     = '0;
                    c_d.q     = dvd[QW-1] ? (-dvd) : dvd;
                    c_d.d     = dvs[DW-1] ? (-dvs) : dvs;
                    c_d.neg_q = dvd[QW-1] ^ dvs[DW-1];
                    c_d.neg_r = dvd[QW-1];
                end
            end
            ST_STEP: begin
                c_d.p   = pnext;
                c_d.q   = {c_q.q[QW-2:0], ~pnext[PW-1]};
                c_d.cnt = c_q.cnt + CW'(1);
                if (c_q.cnt == CW'(QW - 1)) begin
                    c_d.state = ST_FIN;
                end
            end
            default: begin
                c_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy = (c_q.state != ST_IDLE);
    assign done = (c_q.state == ST_FIN);

    sdiv_fixup #(.DW(DW)) fix_i (
        .p_in     (c_q.p),
        .qmag_in  (c_q.q),
        .dmag_in  (c_q.d),
        .neg_q_in (c_q.neg_q),
        .neg_r_in (c_q.neg_r),
        .dz_o     (dz),
        .quo_o    (quo),
        .rem_o    (rem)
    );
endmodule

// File: rtl/sdiv_mmio.sv
module sdiv_mmio #(
    parameter int DW = 32,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    import sdiv_pkg::*;

    typedef struct packed {
        logic [DW-1:0] dvsr;
        logic [DW-1:0] dvd32;
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic [DW-1:0] remm;
        logic [DW-1:0] quom;
        logic          mode64;
    } bank_s;

    bank_s r_q, r_d;

    function automatic logic at_ofs(input logic [AW-1:0] a, input int ofs);
        logic [AW-1:0] o;
        o = AW'(ofs);
        return a[AW-1:2] == o[AW-1:2];
    endfunction

    logic          accept, start;
    logic          core_busy, core_done, core_dz;
    logic [DW-1:0] core_quo, core_rem;
    logic [2*DW-1:0] dvd_w;

    assign accept = wr_en && !core_busy;
    assign start  = accept && (at_ofs(wr_addr, OFS_DVD32) || at_ofs(wr_addr, OFS_LO));
    assign dvd_w  = at_ofs(wr_addr, OFS_LO) ? {r_q.hi, wr_data}
                                            : {{DW{wr_data[DW-1]}}, wr_data};

    sdiv_core #(.DW(DW)) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .dvd   (dvd_w),
        .dvs   (r_q.dvsr),
        .busy  (core_busy),
        .done  (core_done),
        .dz    (core_dz),
        .quo   (core_quo),
        .rem   (core_rem)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            if (at_ofs(wr_addr, OFS_DVSR)) r_d.dvsr = wr_data;
            if (at_ofs(wr_addr, OFS_HI))   r_d.hi   = wr_data;
            if (at_ofs(wr_addr, OFS_REMM)) r_d.remm = wr_data;
            if (at_ofs(wr_addr, OFS_QUOM)) r_d.quom = wr_data;
            if (at_ofs(wr_addr, OFS_DVD32)) begin
                r_d.dvd32  = wr_data;
                r_d.mode64 = 1'b0;
            end
            if (at_ofs(wr_addr, OFS_LO)) begin
                r_d.lo     = wr_data;
                r_d.mode64 = 1'b1;
            end
        end
        if (core_done) begin
            r_d.hi   = core_rem;
            r_d.remm = core_rem;
            r_d.lo   = core_quo;
            r_d.quom = core_quo;
            if (!r_q.mode64 && !core_dz) begin
                r_d.dvd32 = core_quo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (at_ofs(rd_addr, OFS_DVSR))  rd_data = r_q.dvsr;
        if (at_ofs(rd_addr, OFS_DVD32)) rd_data = r_q.dvd32;
        if (at_ofs(rd_addr, OFS_HI))    rd_data = r_q.hi;
        if (at_ofs(rd_addr, OFS_LO))    rd_data = r_q.lo;
        if (at_ofs(rd_addr, OFS_REMM))  rd_data = r_q.remm;
        if (at_ofs(rd_addr, OFS_QUOM))  rd_data = r_q.quom;
    end

    assign busy = core_busy;
endmodule

// File: rtl/sdiv_mmio_chk.sv
module sdiv_mmio_chk #(
    parameter int DW = 32,
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic          busy,
    input logic [DW-1:0] dvsr,
    input logic [DW-1:0] hi,
    input logic [DW-1:0] lo,
    input logic [DW-1:0] remm,
    input logic [DW-1:0] quom
);
    localparam int LAT = 2 * DW + 1;
    localparam int RW  = $clog2(LAT + 1) + 1;

    logic [RW-1:0] run_q;
    logic          launch;

    assign launch = wr_en && ((wr_addr[AW-1:2] == 7'h41) || (wr_addr[AW-1:2] == 7'h45));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + RW'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R9
    busy_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < RW'(LAT)));

    // R9
    busy_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_q != '0) |-> (run_q == RW'(LAT)));

    // R3
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch));

    // R10
    frozen_dvsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dvsr));

    // R4
    mirror_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (lo == quom && hi == remm));
endmodule

bind sdiv_mmio sdiv_mmio_chk #(.DW(DW), .AW(AW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .busy    (busy),
    .dvsr    (r_q.dvsr),
    .hi      (r_q.hi),
    .lo      (r_q.lo),
    .remm    (r_q.remm),
    .quom    (r_q.quom)
);

// File: tb/sdiv_mmio_test.sv
module sdiv_mmio_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [8:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] sh104 = '0;

    logic [8:0]  exp_addr[$];
    logic [31:0] exp_val[$];
    string       exp_tag[$];
    logic [8:0]  m_a;
    logic [31:0] m_v;
    string       m_t;

    always #2 clk = ~clk;

    sdiv_mmio uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    // monitor: pops one expected register value per cycle and compares
    initial begin
        forever begin
            @(negedge clk);
            if (exp_addr.size() != 0) begin
                m_a = exp_addr.pop_front();
                m_v = exp_val.pop_front();
                m_t = exp_tag.pop_front();
                rd_addr = m_a;
                #1;
                n_cmp++;
                if (rd_data !== m_v) begin
                    n_bad++;
                    $display("FAIL %s: offset %h got %h expected %h", m_t, m_a, rd_data, m_v);
                end
            end
        end
    end

    task automatic expect_reg(input logic [8:0] a, input logic [31:0] v, input string t);
        exp_addr.push_back(a);
        exp_val.push_back(v);
        exp_tag.push_back(t);
    endtask

    task automatic flush();
        while (exp_addr.size() != 0) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string t, input int got, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", t, got, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 300) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic model(input bit m64, input logic [31:0] hi, input logic [31:0] lo,
                         input logic [31:0] dvs, output logic [31:0] q, output logic [31:0] r);
        longint dvd, dv, qq, rr;
        dvd = m64 ? longint'({hi, lo}) : longint'($signed(lo));
        dv  = longint'($signed(dvs));
        if (dvs == 0) begin
            q = '0; r = '0;
        end else if (dvd == 64'sh8000000000000000 && dv == -1) begin
            q = 32'h7FFFFFFF; r = '0;
        end else begin
            qq = dvd / dv;
            rr = dvd % dv;
            if (qq > 64'sd2147483647)       q = 32'h7FFFFFFF;
            else if (qq < -64'sd2147483648) q = 32'h80000000;
            else                            q = qq[31:0];
            r = rr[31:0];
        end
    endtask

    // driver: launches one division and queues the expected register image
    task automatic run_div(input bit m64, input logic [31:0] hi, input logic [31:0] lo,
                           input logic [31:0] dvs, input string t);
        logic [31:0] q, r;
        int n;
        wr(9'h100, dvs);
        if (m64) wr(9'h110, hi);
        wr(m64 ? 9'h114 : 9'h104, lo);
        count_busy(n);
        check(n == 65, {t, " R9 busy length"}, n, 65);
        model(m64, hi, lo, dvs, q, r);
        if (!m64) sh104 = (dvs == 0) ? lo : q;
        expect_reg(9'h104, sh104, {t, (m64 ? " R5 104 kept" : " R4 quot@104")});
        expect_reg(9'h114, q, {t, " R4/R5 quot@114"});
        expect_reg(9'h11C, q, {t, " R4/R5 quot@11C"});
        expect_reg(9'h110, r, {t, " R4/R5 rem@110"});
        expect_reg(9'h118, r, {t, " R4/R5 rem@118"});
        expect_reg(9'h100, dvs, {t, " R2 divisor"});
        flush();
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        expect_reg(9'h100, 0, "R1 reset 100");
        expect_reg(9'h104, 0, "R1 reset 104");
        expect_reg(9'h110, 0, "R1 reset 110");
        expect_reg(9'h114, 0, "R1 reset 114");
        expect_reg(9'h118, 0, "R1 reset 118");
        expect_reg(9'h11C, 0, "R1 reset 11C");
        flush();

        // R2 plain stores, no launch
        wr(9'h110, 32'h1234_5678);
        wr(9'h118, 32'hCAFE_0001);
        check(busy == 1'b0, "R2 no launch from 110", busy, 0);
        expect_reg(9'h110, 32'h1234_5678, "R2 readback 110");
        expect_reg(9'h118, 32'hCAFE_0001, "R2 readback 118");
        // R11 unmapped offsets
        expect_reg(9'h108, 0, "R11 unmapped 108");
        expect_reg(9'h000, 0, "R11 unmapped 000");
        flush();

        // R3 R4 R6 sign combinations in the 32-bit form
        run_div(0, 0, 32'd100, 32'd7, "R6 +/+");
        run_div(0, 0, -32'sd100, 32'd7, "R6 -/+");
        run_div(0, 0, 32'd100, -32'sd7, "R6 +/-");
        run_div(0, 0, -32'sd100, -32'sd7, "R3 -/-");
        run_div(0, 0, 32'd5, 32'd9, "R6 small");

        // R5 64-bit form
        run_div(1, 32'd1, 32'd0, 32'd3, "R5 2^32/3");
        run_div(1, 32'hFFFF_FFFE, 32'h1234_5678, 32'd1000, "R5 negative");

        // R7 saturation and boundary
        run_div(1, 32'd1, 32'd0, 32'd1, "R7 pos sat");
        run_div(1, 32'hFFFF_FFFF, 32'd0, 32'd1, "R7 neg sat");
        run_div(1, 32'hFFFF_FFFF, 32'd0, -32'sd1, "R7 pos sat via -1");
        run_div(1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, "R7 exact min");
        run_div(0, 0, 32'h8000_0000, -32'sd1, "R7 min/-1");
        run_div(1, 32'h0000_0007, 32'h0000_0005, 32'd3, "R7 rem kept");

        // R8 zero divisor in both forms
        run_div(0, 0, 32'd77, 32'd0, "R8 zero 32");
        run_div(1, 32'd5, 32'd9, 32'd0, "R8 zero 64");

        // R10 writes during busy are dropped
        run_div(0, 0, 32'd20, 32'd6, "R10 prep");
        wr(9'h100, 32'd7);
        wr(9'h104, 32'd50);
        check(busy == 1'b1, "R10 launched", busy, 1);
        wr(9'h100, 32'd3);
        wr(9'h104, 32'd99);
        wr(9'h110, 32'h55);
        expect_reg(9'h110, 32'd2, "R10 old rem during busy");
        expect_reg(9'h100, 32'd7, "R10 divisor frozen");
        count_busy(n);
        check(n > 0 && n < 65, "R10 busy still running", n, 60);
        expect_reg(9'h104, 32'd7, "R10 quot after busy");
        expect_reg(9'h110, 32'd1, "R10 rem after busy");
        expect_reg(9'h100, 32'd7, "R10 divisor kept");
        flush();
        check(busy == 1'b0, "R10 no relaunch", busy, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule